// File: doc/BRIEF.md
# Cluster Unit I/O Control Responder

This block is one addressable unit on a processor-cluster bus. Every cycle that the request strobe is high it takes a 32-bit privileged I/O control word and decodes it. It checks whether the word belongs to the unit-control group, and whether the cluster and unit fields name this unit's strapped address. It then answers one of three commands. The first command drives a fixed-length reset pulse to the devices behind the unit. The second returns the unit's 16-bit fault status. The third returns the fault status and clears it in the same step.

Each request gets exactly one response, one cycle after the strobe. The response carries a 2-bit condition code and a 32-bit result word. Fault events reach the unit as one-cycle set pulses on a bit vector, and they accumulate in a local status register. A fault is pending when any status bit is set. Bits are numbered with bit 0 as the MSB of the 32-bit word, so bit n sits at vector index 31-n.

Top module: `cluster_unit_ioctl`

## Requirements
- R1: A word belongs to the group only when bits 1 to 7 (`instr_i[30:24]`) equal 7'h4F. The command sits in bits 15 to 17 (`instr_i[16:14]`): 001 is reset unit, 010 is poll, 011 is poll-and-clear.
- R2: Every request strobe yields `rsp_valid_o` high for exactly one cycle, in the cycle after the strobe. There is no response without a strobe.
- R3: The cluster field is bits 18 to 20 (`instr_i[13:11]`) and the unit field is bits 21 to 23 (`instr_i[10:8]`). For the address to be recognized, the cluster field must equal `strap_cluster_i`. When the cluster is below 7, the unit field must also equal `strap_unit_i`.
- R4: When the cluster field is 7, the unit field is ignored in matching.
- R5: In clusters 0 to 6, unit values 6 and 7 are reserved for the memory and processor interfaces, so this block never recognizes them.
- R6: The condition code is 00 for "recognized, no fault pending", 01 for "fault pending" and 11 for "not recognized". The code 10 never appears. A not-recognized response carries a result of zero.
- R7: A recognized poll returns the status in bits 16 to 31 (`rsp_data_o[15:0]`) and repeats it in bits 0 to 15 (`rsp_data_o[31:16]`). The code is 01 when any status bit is set and 00 otherwise. A poll leaves the status unchanged.
- R8: A recognized poll-and-clear returns the same result as a poll and then clears the status register.
- R9: A fault set pulse that arrives in the cycle of a clear survives the clear. Set pulses accumulate until a clear.
- R10: A recognized reset-unit command gives code 00 and result zero, and drives `io_reset_o` high for exactly 4 cycles, starting in the cycle after the strobe.
- R11: A new recognized reset-unit command that arrives while the pulse is active restarts the 4-cycle count.
- R12: Any other opcode or command value answers with code 11. It does not clear the status and does not start a reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, one cycle per command |
| instr_i | input | 32 | Control word, sampled with req_i |
| strap_cluster_i | input | 3 | Strapped cluster address of this unit |
| strap_unit_i | input | 3 | Strapped unit address of this unit |
| fault_set_i | input | 16 | Fault set pulses, one bit per status bit |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_cc_o | output | 2 | Condition code |
| rsp_data_o | output | 32 | Result word, status in both halves |
| io_reset_o | output | 1 | Reset pulse to attached devices |

## Verification
The assertions assume that the strap inputs do not change while a request is in flight. They also assume that a strobe is a single-cycle event, so that a response can be tied back to the request before it. The stimulus changes the straps only in idle cycles. It drives each strobe for one cycle at the falling edge, and clears `fault_set_i` again after every pulse, so each set event is counted once.

// File: rtl/ioctl_pkg.sv
`timescale 1ns/1ps
package ioctl_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 3;
  localparam logic [6:0] GROUP_OPC = 7'h4F;

  // field positions, bit 0 = MSB of the word
  localparam int OPC_HI = 30;
  localparam int OPC_LO = 24;
  localparam int CMD_HI = 16;
  localparam int CMD_LO = 14;
  localparam int CL_HI  = 13;
  localparam int CL_LO  = 11;
  localparam int UN_HI  = 10;
  localparam int UN_LO  = 8;

  localparam logic [ADDR_W-1:0] SYS_CLUSTER = 3'd7;
  localparam logic [ADDR_W-1:0] MEM_IF_UNIT = 3'd6;
  localparam logic [ADDR_W-1:0] PROC_IF_UNIT = 3'd7;

  typedef enum logic [2:0] {
    CMD_RESET   = 3'b001,
    CMD_POLL    = 3'b010,
    CMD_POLLCLR = 3'b011
  } cmd_e;

  typedef enum logic [1:0] {
    CC_IDLE   = 2'b00,
    CC_PEND   = 2'b01,
    CC_NOADDR = 2'b11
  } cc_e;

  typedef struct packed {
    logic hit;
    logic do_reset;
    logic do_poll;
    logic do_clear;
  } dec_t;
endpackage

// File: rtl/ioctl_decode.sv
`timescale 1ns/1ps
module ioctl_decode
  import ioctl_pkg::*;
(
  input  logic [WORD_W-1:0] instr_i,
  input  logic [ADDR_W-1:0] strap_cluster_i,
  input  logic [ADDR_W-1:0] strap_unit_i,
  output dec_t              dec_o
);
  logic [6:0]        opc;
  logic [2:0]        cmd;
  logic [ADDR_W-1:0] cl;
  logic [ADDR_W-1:0] un;
  logic              in_group;
  logic              cl_match;
  logic              un_match;
  logic              un_reserved;
  logic              cmd_known;

  assign opc = instr_i[OPC_HI:OPC_LO];
  assign cmd = instr_i[CMD_HI:CMD_LO];
  assign cl  = instr_i[CL_HI:CL_LO];
  assign un  = instr_i[UN_HI:UN_LO];

  logic unused_bits;
  assign unused_bits = ^{instr_i[31], instr_i[23:17], instr_i[7:0]};

  assign in_group    = (opc == GROUP_OPC);
  assign cl_match    = (cl == strap_cluster_i);
  assign un_reserved = (un == MEM_IF_UNIT) || (un == PROC_IF_UNIT);
  // system cluster ignores unit field
  assign un_match    = (cl == SYS_CLUSTER) ? 1'b1
                     : (!un_reserved && (un == strap_unit_i));
  assign cmd_known   = (cmd == CMD_RESET) || (cmd == CMD_POLL) || (cmd == CMD_POLLCLR);

  always_comb begin
    dec_o          = '0;
    dec_o.hit      = in_group && cmd_known && cl_match && un_match;
    dec_o.do_reset = dec_o.hit && (cmd == CMD_RESET);
    dec_o.do_poll  = dec_o.hit && ((cmd == CMD_POLL) || (cmd == CMD_POLLCLR));
    dec_o.do_clear = dec_o.hit && (cmd == CMD_POLLCLR);
  end
endmodule

// File: rtl/fault_status_reg.sv
`timescale 1ns/1ps
module fault_status_reg #(
  parameter int STATUS_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [STATUS_W-1:0] set_i,
  input  logic                clr_i,
  output logic [STATUS_W-1:0] status_o,
  output logic                pending_o
);
  logic [STATUS_W-1:0] status_q;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (clr_i ? '0 : status_q) | set_i;
  end

  assign status_o  = status_q;
  assign pending_o = |status_q;
endmodule

// File: rtl/reset_pulse_gen.sv
`timescale 1ns/1ps
module reset_pulse_gen #(
  parameter int CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic pulse_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (start_i)     cnt_q <= LOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/cluster_unit_ioctl.sv
`timescale 1ns/1ps
module cluster_unit_ioctl
  import ioctl_pkg::*;
#(
  parameter int STATUS_W     = 16,
  parameter int RESET_CYCLES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [31:0]         instr_i,
  input  logic [2:0]          strap_cluster_i,
  input  logic [2:0]          strap_unit_i,
  input  logic [STATUS_W-1:0] fault_set_i,
  output logic                rsp_valid_o,
  output logic [1:0]          rsp_cc_o,
  output logic [31:0]         rsp_data_o,
  output logic                io_reset_o
);
  localparam int HALF_W = WORD_W / 2;

  dec_t                dec;
  logic [STATUS_W-1:0] status;
  logic                pending;
  logic [HALF_W-1:0]   status_half;
  logic                clr_go;
  logic                rst_go;
  logic [1:0]          cc_d;
  logic [WORD_W-1:0]   data_d;
  logic                valid_q;
  logic [1:0]          cc_q;
  logic [WORD_W-1:0]   data_q;

  ioctl_decode u_dec (
    .instr_i         (instr_i),
    .strap_cluster_i (strap_cluster_i),
    .strap_unit_i    (strap_unit_i),
    .dec_o           (dec)
  );

  assign clr_go = req_i && dec.do_clear;
  assign rst_go = req_i && dec.do_reset;

  fault_status_reg #(.STATUS_W(STATUS_W)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (fault_set_i),
    .clr_i     (clr_go),
    .status_o  (status),
    .pending_o (pending)
  );

  reset_pulse_gen #(.CYCLES(RESET_CYCLES)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (rst_go),
    .pulse_o (io_reset_o)
  );

  generate
    if (STATUS_W >= HALF_W) begin : g_trunc
      assign status_half = status[HALF_W-1:0];
    end else begin : g_pad
      assign status_half = {{(HALF_W-STATUS_W){1'b0}}, status};
    end
  endgenerate

  always_comb begin
    cc_d   = CC_NOADDR;
    data_d = '0;
    if (dec.do_poll) begin
      cc_d   = pending ? CC_PEND : CC_IDLE;
      data_d = {status_half, status_half};
    end else if (dec.do_reset) begin
      cc_d = CC_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      cc_q    <= CC_IDLE;
      data_q  <= '0;
    end else begin
      valid_q <= req_i;
      if (req_i) begin
        cc_q   <= cc_d;
        data_q <= data_d;
      end
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_cc_o    = cc_q;
  assign rsp_data_o  = data_q;
endmodule

// File: rtl/cluster_unit_ioctl_chk.sv
`timescale 1ns/1ps
module cluster_unit_ioctl_chk #(
  parameter int RESET_CYCLES = 4
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        rsp_valid_o,
  input logic [1:0]  rsp_cc_o,
  input logic [31:0] rsp_data_o,
  input logic        io_reset_o
);
  localparam int SW = $clog2(RESET_CYCLES + 1) + 1;
  localparam logic [SW-1:0] SAT = SW'(RESET_CYCLES);

  logic [SW-1:0] since_req;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               since_req <= SAT;
    else if (req_i)            since_req <= '0;
    else if (since_req != SAT) since_req <= since_req + 1'b1;
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_i));
  // R6
  cc_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_cc_o != 2'b10);
  // R6
  noaddr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_cc_o == 2'b11) |-> rsp_data_o == '0);
  // R7
  halves_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_data_o[31:16] == rsp_data_o[15:0]);
  // R7
  pend_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_cc_o == 2'b01) |-> rsp_data_o != '0);
  // R7
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_cc_o == 2'b00) |-> rsp_data_o == '0);
  // R10
  pulse_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(io_reset_o) |-> $past(req_i));
  // R10
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_reset_o |-> since_req < SAT);
endmodule

bind cluster_unit_ioctl cluster_unit_ioctl_chk #(.RESET_CYCLES(RESET_CYCLES)) u_chk (.*);

// File: tb/cluster_unit_ioctl_test.sv
`timescale 1ns/1ps
module cluster_unit_ioctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] instr = '0;
  logic [2:0]  s_cl = 3'd2;
  logic [2:0]  s_un = 3'd3;
  logic [15:0] fset = '0;
  logic        valid;
  logic [1:0]  cc;
  logic [31:0] data;
  logic        iorst;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cluster_unit_ioctl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .instr_i(instr),
    .strap_cluster_i(s_cl), .strap_unit_i(s_un), .fault_set_i(fset),
    .rsp_valid_o(valid), .rsp_cc_o(cc), .rsp_data_o(data), .io_reset_o(iorst)
  );

  function automatic logic [31:0] mk(input logic [6:0] op, input logic [2:0] cmd,
                                     input logic [2:0] cl, input logic [2:0] un);
    logic [31:0] w;
    w = 32'h0090_00A5; // unrelated bits set
    w[30:24] = op; w[16:14] = cmd; w[13:11] = cl; w[10:8] = un;
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [15:0] fs);
    @(negedge clk); req = 1'b1; instr = w; fset = fs;
    @(negedge clk); req = 1'b0; fset = '0;
  endtask

  task automatic pulse_fault(input logic [15:0] v);
    @(negedge clk); fset = v;
    @(negedge clk); fset = '0;
  endtask

  task automatic expect_rsp(input string tag, input logic [1:0] ecc, input logic [31:0] edata);
    chk(valid == 1'b1, {tag, " valid"}, 64'(valid), 64'd1);
    chk(cc == ecc, {tag, " cc"}, 64'(cc), 64'(ecc));
    chk(data == edata, {tag, " data"}, 64'(data), 64'(edata));
  endtask

  task automatic count_pulse(output int n);
    n = 0;
    while (iorst && n < 20) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset_state;
    chk(valid == 1'b0, "reset valid", 64'(valid), 64'd0);
    chk(iorst == 1'b0, "reset io_reset", 64'(iorst), 64'd0);
  endtask

  task automatic t_poll_basic;
    issue(mk(7'h4F, 3'b010, 3'd2, 3'd3), '0);
    expect_rsp("R7 poll idle", 2'b00, 32'h0);
    @(negedge clk);
    chk(valid == 1'b0, "R2 single valid", 64'(valid), 64'd0);
    pulse_fault(16'h0005);
    pulse_fault(16'h0100);
    issue(mk(7'h4F, 3'b010, 3'd2, 3'd3), '0);
    expect_rsp("R9 R7 poll pend", 2'b01, 32'h0105_0105);
    issue(mk(7'h4F, 3'b010, 3'd2, 3'd3), '0);
    expect_rsp("R7 poll keeps", 2'b01, 32'h0105_0105);
  endtask

  task automatic t_pollclr;
    issue(mk(7'h4F, 3'b011, 3'd2, 3'd3), '0);
    expect_rsp("R8 pollclr rsp", 2'b01, 32'h0105_0105);
    issue(mk(7'h4F, 3'b010, 3'd2, 3'd3), '0);
    expect_rsp("R8 after clear", 2'b00, 32'h0);
  endtask

  task automatic t_set_vs_clear;
    pulse_fault(16'h0020);
    issue(mk(7'h4F, 3'b011, 3'd2, 3'd3), 16'h8000);
    expect_rsp("R9 clr old", 2'b01, 32'h0020_0020);
    issue(mk(7'h4F, 3'b010, 3'd2, 3'd3), '0);
    expect_rsp("R9 set survives", 2'b01, 32'h8000_8000);
    issue(mk(7'h4F, 3'b011, 3'd2, 3'd3), '0);
  endtask

  task automatic t_reset_unit;
    int n;
    issue(mk(7'h4F, 3'b001, 3'd2, 3'd3), '0);
    expect_rsp("R10 reset rsp", 2'b00, 32'h0);
    count_pulse(n);
    chk(n == 4, "R10 pulse len", 64'(n), 64'd4);
    issue(mk(7'h4F, 3'b001, 3'd2, 3'd3), '0);
    issue(mk(7'h4F, 3'b001, 3'd2, 3'd3), '0);
    count_pulse(n);
    chk(n == 4, "R11 restart", 64'(n), 64'd4);
    issue(mk(7'h4F, 3'b001, 3'd2, 3'd4), '0);
    expect_rsp("R3 reset miss", 2'b11, 32'h0);
    chk(iorst == 1'b0, "R3 no pulse", 64'(iorst), 64'd0);
  endtask

  task automatic t_addressing;
    pulse_fault(16'h0001);
    issue(mk(7'h4F, 3'b010, 3'd1, 3'd3), '0);
    expect_rsp("R3 wrong cluster", 2'b11, 32'h0);
    issue(mk(7'h4F, 3'b010, 3'd2, 3'd2), '0);
    expect_rsp("R3 wrong unit", 2'b11, 32'h0);
    @(negedge clk); s_cl = 3'd7; s_un = 3'd0;
    issue(mk(7'h4F, 3'b010, 3'd7, 3'd5), '0);
    expect_rsp("R4 sys cluster", 2'b01, 32'h0001_0001);
    @(negedge clk); s_cl = 3'd0; s_un = 3'd6;
    issue(mk(7'h4F, 3'b010, 3'd0, 3'd6), '0);
    expect_rsp("R5 unit6 reserved", 2'b11, 32'h0);
    @(negedge clk); s_un = 3'd7;
    issue(mk(7'h4F, 3'b010, 3'd0, 3'd7), '0);
    expect_rsp("R5 unit7 reserved", 2'b11, 32'h0);
    @(negedge clk); s_un = 3'd5;
    issue(mk(7'h4F, 3'b010, 3'd0, 3'd5), '0);
    expect_rsp("R3 cluster0 unit5", 2'b01, 32'h0001_0001);
  endtask

  task automatic t_unknown;
    issue(mk(7'h4E, 3'b011, 3'd0, 3'd5), '0);
    expect_rsp("R12 bad opcode", 2'b11, 32'h0);
    chk(iorst == 1'b0, "R12 no pulse op", 64'(iorst), 64'd0);
    issue(mk(7'h4F, 3'b000, 3'd0, 3'd5), '0);
    expect_rsp("R12 cmd 000", 2'b11, 32'h0);
    issue(mk(7'h4F, 3'b111, 3'd0, 3'd5), '0);
    expect_rsp("R1 R12 cmd 111", 2'b11, 32'h0);
    chk(iorst == 1'b0, "R12 no pulse cmd", 64'(iorst), 64'd0);
    issue(mk(7'h4F, 3'b010, 3'd0, 3'd5), '0);
    expect_rsp("R12 status kept", 2'b01, 32'h0001_0001);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_poll_basic();
    t_pollclr();
    t_set_vs_clear();
    t_reset_unit();
    t_addressing();
    t_unknown();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule